// File: doc/BRIEF.md
# Program-Driven Stream DMA Engine

This engine moves words between a synchronous single-port SRAM and one streaming port. It follows a small program that is kept in the SRAM itself, with no register set to load. When another master raises a one-cycle start stimulus, the engine reads a program pointer from a fixed boot cell. It then reads a header cell that selects the port, and executes instructions of five cells each. Each transfer instruction first pushes its own opcode cell onto the port, so the routine at the far end knows how to treat the words that follow. It then streams the counted words in one of four modes: out or in, narrow (16-bit) or wide (18-bit). A finish instruction pulses the stimulus line of one selected master and sends the engine back to idle.

Wide words take two SRAM cells: the upper bits go in the lower-addressed cell and the low sixteen bits in the next one. The SRAM has a one-cycle read latency. The port uses valid/ready handshakes in both directions.

Top module: `prog_dma`

## Requirements
- R1: After reset, and whenever `busy` is low, the engine drives no SRAM access, no port handshake and no master stimulus.
- R2: A high `stim_i` while idle starts a run. The engine reads the cell at BOOT_ADDR, zero-extends it as the program pointer P, and drives the cell at P onto `port_sel` until the next run replaces it.
- R3: Instructions start at P+1 and each takes five cells: [0] opcode/routine, [1] count high, [2] count low, [3] address high, [4] address low. The next instruction follows five cells later. The address is 20 bits (the high cell supplies bits 19:16 from its bits 3:0) and the upper bits of the high cells are ignored.
- R4: Opcode cell bit 15 = 1 marks a transfer. Bit 14 selects the direction (0 = SRAM to port, 1 = port to SRAM) and bit 13 selects the width (1 = 18-bit). The whole opcode cell, zero-extended to 18 bits, is the first port word of the transfer.
- R5: A narrow outbound transfer sends each SRAM cell, zero-extended, reading from consecutive addresses that start at the instruction's address.
- R6: A wide outbound transfer builds each port word from bits 1:0 of one cell (as bits 17:16) and all of the next cell (as bits 15:0).
- R7: A narrow inbound transfer writes bits 15:0 of each received port word to consecutive cells.
- R8: A wide inbound transfer writes bits 17:16 of each received word, zero-extended, to one cell and bits 15:0 to the next.
- R9: The word count is 18 bits (high cell bits 1:0, then the low cell). A count of zero sends the opcode cell only. No cell beyond the counted span is written.
- R10: An opcode cell with bit 15 = 0 is a finish. It raises `stim_o[k]` for exactly one cycle, where k is its low bits, and then `busy` falls.
- R11: `stim_i` has no effect while a run is in progress.
- R12: Port output data stay stable while `pout_valid` is high and `pout_ready` is low, and the engine never offers and accepts port words in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stim_i | input | 1 | Start stimulus from a master |
| stim_o | output | N_MASTERS | One-cycle completion stimulus per master |
| busy | output | 1 | High while a program runs |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write (with mem_en) |
| mem_addr | output | ADDR_W | SRAM cell address |
| mem_wdata | output | CELL_W | SRAM write data |
| mem_rdata | input | CELL_W | SRAM read data, valid one cycle after a read |
| port_sel | output | CELL_W | Port selection from the program header |
| pout_valid | output | 1 | Outbound port word valid |
| pout_ready | input | 1 | Far end accepts outbound word |
| pout_data | output | PWORD_W | Outbound port word |
| pin_valid | input | 1 | Inbound port word valid |
| pin_ready | output | 1 | Engine accepts inbound word |
| pin_data | input | PWORD_W | Inbound port word |

## Verification
The bench builds the engine with its default widths (20-bit addresses, 16-bit cells, 18-bit port words, 18-bit counts) and four masters, with the boot cell moved to address 3. It sweeps every transfer mode against counts 0 to 4, each with a free-flowing port and a stalling port. Each program adds a second fixed transfer and a finish aimed at a different master, which brings in pointer advance, ignored high-cell bits, zero-count instructions, the last-cell boundary and restarts while busy.

// File: rtl/prog_dma_pkg.sv
package prog_dma_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_BOOT_RD,
      ST_BOOT_CAP,
      ST_HDR_RD,
      ST_HDR_CAP,
      ST_FETCH_RD,
      ST_FETCH_CAP,
      ST_ROUTINE,
      ST_SEND_RD,
      ST_SEND_CAP,
      ST_SEND_OUT,
      ST_RECV_IN,
      ST_RECV_WR,
      ST_NEXT,
      ST_FINISH
   } dma_state_t;

   localparam int unsigned INSTR_CELLS = 5;

endpackage

// File: rtl/dmac_span.sv
module dmac_span #(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned CELL_W = 16,
   parameter int unsigned CNT_W  = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [2:0]        ld_idx,
   input  logic [CELL_W-1:0] ld_data,
   input  logic              step_addr,
   input  logic              step_cnt,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              cnt_zero,
   output logic              cnt_last
);

   localparam int unsigned ADDR_HI_W = ADDR_W - CELL_W;
   localparam int unsigned CNT_HI_W  = CNT_W - CELL_W;

   if (ADDR_W <= CELL_W || ADDR_HI_W > CELL_W) begin : g_bad_addr_w
      $error("dmac_span: ADDR_W must exceed CELL_W by at most CELL_W");
   end
   if (CNT_W <= CELL_W || CNT_HI_W > CELL_W) begin : g_bad_cnt_w
      $error("dmac_span: CNT_W must exceed CELL_W by at most CELL_W");
   end

   logic [ADDR_W-1:0] addr_r;
   logic [CNT_W-1:0]  cnt_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_r <= '0;
         cnt_r  <= '0;
      end else if (ld_en) begin
         case (ld_idx)
            3'd1:    cnt_r[CNT_W-1:CELL_W]   <= ld_data[CNT_HI_W-1:0];
            3'd2:    cnt_r[CELL_W-1:0]       <= ld_data;
            3'd3:    addr_r[ADDR_W-1:CELL_W] <= ld_data[ADDR_HI_W-1:0];
            3'd4:    addr_r[CELL_W-1:0]      <= ld_data;
            default: ;
         endcase
      end else begin
         if (step_addr) addr_r <= addr_r + 1'b1;
         if (step_cnt)  cnt_r  <= cnt_r - 1'b1;
      end
   end

   assign cur_addr = addr_r;
   assign cnt_zero = (cnt_r == '0);
   assign cnt_last = (cnt_r == CNT_W'(1));

   // R9: the word count never wraps below zero
   assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      step_cnt |-> (cnt_r != '0));

endmodule

// File: rtl/dmac_stim_dec.sv
module dmac_stim_dec #(
   parameter int unsigned N_MASTERS = 4,
   parameter int unsigned IDX_W     = 2
) (
   input  logic                 fire,
   input  logic [IDX_W-1:0]     idx,
   output logic [N_MASTERS-1:0] stim
);

   if (N_MASTERS < 2 || (1 << IDX_W) < N_MASTERS) begin : g_bad_masters
      $error("dmac_stim_dec: IDX_W too small for N_MASTERS");
   end

   for (genvar m = 0; m < N_MASTERS; m++) begin : g_line
      assign stim[m] = fire && (idx == IDX_W'(m));
   end

endmodule

// File: rtl/prog_dma.sv
module prog_dma
   import prog_dma_pkg::*;
#(
   parameter int unsigned ADDR_W    = 20,
   parameter int unsigned CELL_W    = 16,
   parameter int unsigned PWORD_W   = 18,
   parameter int unsigned CNT_W     = 18,
   parameter int unsigned N_MASTERS = 4,
   parameter int unsigned BOOT_ADDR = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 stim_i,
   output logic [N_MASTERS-1:0] stim_o,
   output logic                 busy,
   output logic                 mem_en,
   output logic                 mem_we,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [CELL_W-1:0]    mem_wdata,
   input  logic [CELL_W-1:0]    mem_rdata,
   output logic [CELL_W-1:0]    port_sel,
   output logic                 pout_valid,
   input  logic                 pout_ready,
   output logic [PWORD_W-1:0]   pout_data,
   input  logic                 pin_valid,
   output logic                 pin_ready,
   input  logic [PWORD_W-1:0]   pin_data
);

   localparam int unsigned EXT_W  = PWORD_W - CELL_W;
   localparam int unsigned MIDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;
   localparam int unsigned PTR_PAD = ADDR_W - CELL_W;

   if (PWORD_W <= CELL_W || EXT_W > CELL_W) begin : g_bad_pword
      $error("prog_dma: PWORD_W must exceed CELL_W by at most CELL_W");
   end
   if (CELL_W < 4 || MIDX_W > CELL_W - 3) begin : g_bad_cell
      $error("prog_dma: CELL_W too narrow for opcode and master index");
   end
   if (BOOT_ADDR >= (64'd1 << ADDR_W)) begin : g_bad_boot
      $error("prog_dma: BOOT_ADDR outside the address space");
   end

   dma_state_t          state;
   logic [ADDR_W-1:0]   ip;
   logic [CELL_W-1:0]   op_cell;
   logic [CELL_W-1:0]   port_sel_r;
   logic [2:0]          fidx;
   logic                half;
   logic [EXT_W-1:0]    ext_r;
   logic [PWORD_W-1:0]  word_r;

   logic                dir_in, wide;
   logic [ADDR_W-1:0]   span_addr;
   logic                cnt_zero, cnt_last;
   logic                span_ld, step_addr, step_cnt, wr_hi;

   assign dir_in = op_cell[CELL_W-2];
   assign wide   = op_cell[CELL_W-3];
   assign wr_hi  = wide && !half;

   assign span_ld   = (state == ST_FETCH_CAP) && (fidx != 3'd0);
   assign step_addr = (state == ST_SEND_RD) || (state == ST_RECV_WR);
   assign step_cnt  = ((state == ST_SEND_OUT) && pout_ready) ||
                      ((state == ST_RECV_WR) && !wr_hi);

   dmac_span #(
      .ADDR_W (ADDR_W),
      .CELL_W (CELL_W),
      .CNT_W  (CNT_W)
   ) i_span (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_en     (span_ld),
      .ld_idx    (fidx),
      .ld_data   (mem_rdata),
      .step_addr (step_addr),
      .step_cnt  (step_cnt),
      .cur_addr  (span_addr),
      .cnt_zero  (cnt_zero),
      .cnt_last  (cnt_last)
   );

   dmac_stim_dec #(
      .N_MASTERS (N_MASTERS),
      .IDX_W     (MIDX_W)
   ) i_stim_dec (
      .fire (state == ST_FINISH),
      .idx  (op_cell[MIDX_W-1:0]),
      .stim (stim_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         ip         <= '0;
         op_cell    <= '0;
         port_sel_r <= '0;
         fidx       <= '0;
         half       <= 1'b0;
         ext_r      <= '0;
         word_r     <= '0;
      end else begin
         case (state)
            ST_IDLE:     if (stim_i) state <= ST_BOOT_RD;
            ST_BOOT_RD:  state <= ST_BOOT_CAP;
            ST_BOOT_CAP: begin
               ip    <= {{PTR_PAD{1'b0}}, mem_rdata};
               state <= ST_HDR_RD;
            end
            ST_HDR_RD:   state <= ST_HDR_CAP;
            ST_HDR_CAP: begin
               port_sel_r <= mem_rdata;
               ip         <= ip + 1'b1;
               fidx       <= '0;
               state      <= ST_FETCH_RD;
            end
            ST_FETCH_RD: state <= ST_FETCH_CAP;
            ST_FETCH_CAP: begin
               if (fidx == 3'd0) begin
                  op_cell <= mem_rdata;
                  if (!mem_rdata[CELL_W-1]) begin
                     state <= ST_FINISH;
                  end else begin
                     fidx  <= 3'd1;
                     state <= ST_FETCH_RD;
                  end
               end else if (fidx == 3'(INSTR_CELLS - 1)) begin
                  state <= ST_ROUTINE;
               end else begin
                  fidx  <= fidx + 1'b1;
                  state <= ST_FETCH_RD;
               end
            end
            ST_ROUTINE: if (pout_ready) begin
               half <= 1'b0;
               if (cnt_zero)    state <= ST_NEXT;
               else if (dir_in) state <= ST_RECV_IN;
               else             state <= ST_SEND_RD;
            end
            ST_SEND_RD:  state <= ST_SEND_CAP;
            ST_SEND_CAP: begin
               if (wide && !half) begin
                  ext_r <= mem_rdata[EXT_W-1:0];
                  half  <= 1'b1;
                  state <= ST_SEND_RD;
               end else begin
                  word_r <= wide ? {ext_r, mem_rdata} : {{EXT_W{1'b0}}, mem_rdata};
                  half   <= 1'b0;
                  state  <= ST_SEND_OUT;
               end
            end
            ST_SEND_OUT: if (pout_ready) state <= cnt_last ? ST_NEXT : ST_SEND_RD;
            ST_RECV_IN:  if (pin_valid) begin
               word_r <= pin_data;
               half   <= 1'b0;
               state  <= ST_RECV_WR;
            end
            ST_RECV_WR: begin
               if (wr_hi) begin
                  half <= 1'b1;
               end else begin
                  half  <= 1'b0;
                  state <= cnt_last ? ST_NEXT : ST_RECV_IN;
               end
            end
            ST_NEXT: begin
               ip    <= ip + ADDR_W'(INSTR_CELLS);
               fidx  <= '0;
               state <= ST_FETCH_RD;
            end
            ST_FINISH:   state <= ST_IDLE;
            default:     state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = span_addr;
      mem_wdata = wr_hi ? {{(CELL_W-EXT_W){1'b0}}, word_r[PWORD_W-1:CELL_W]}
                        : word_r[CELL_W-1:0];
      case (state)
         ST_BOOT_RD:  begin mem_en = 1'b1; mem_addr = ADDR_W'(BOOT_ADDR); end
         ST_HDR_RD:   begin mem_en = 1'b1; mem_addr = ip; end
         ST_FETCH_RD: begin mem_en = 1'b1; mem_addr = ip + ADDR_W'(fidx); end
         ST_SEND_RD:  mem_en = 1'b1;
         ST_RECV_WR:  begin mem_en = 1'b1; mem_we = 1'b1; end
         default: ;
      endcase
   end

   assign busy       = (state != ST_IDLE);
   assign port_sel   = port_sel_r;
   assign pout_valid = (state == ST_ROUTINE) || (state == ST_SEND_OUT);
   assign pout_data  = (state == ST_ROUTINE) ? {{EXT_W{1'b0}}, op_cell} : word_r;
   assign pin_ready  = (state == ST_RECV_IN);

   // R1: an idle engine is silent on every interface
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_en && !pout_valid && !pin_ready && (stim_o == '0)));

   // R2: a run only begins after a start stimulus
   assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stim_i));

   // R7: writes are always qualified by the access enable
   assert_write_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_en);

   // R10: at most one master is stimulated, and the run then ends
   assert_stim_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stim_o));
   assert_finish_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stim_o != '0) |=> !busy);

   // R12: an offered word is held until taken; directions never overlap
   assert_hold_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (pout_valid && !pout_ready) |=> (pout_valid && $stable(pout_data)));
   assert_port_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(pout_valid && pin_ready));

endmodule

// File: tb/test_prog_dma.sv
`timescale 1ns/1ps
module test_prog_dma;

   localparam int ADDR_W = 20;
   localparam int CELL_W = 16;
   localparam int PWORD_W = 18;
   localparam int NM = 4;
   localparam int BOOT = 3;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst_n = 1'b0;
   logic              stim_i = 1'b0;
   logic [NM-1:0]     stim_o;
   logic              busy;
   logic              mem_en, mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [CELL_W-1:0] mem_wdata;
   logic [CELL_W-1:0] mem_rdata = '0;
   logic [CELL_W-1:0] port_sel;
   logic              pout_valid;
   logic              pout_ready = 1'b0;
   logic [PWORD_W-1:0] pout_data;
   logic              pin_valid = 1'b0;
   logic              pin_ready;
   logic [PWORD_W-1:0] pin_data = '0;

   prog_dma #(
      .ADDR_W (ADDR_W), .CELL_W (CELL_W), .PWORD_W (PWORD_W),
      .CNT_W (18), .N_MASTERS (NM), .BOOT_ADDR (BOOT)
   ) i_prog_dma (
      .clk (clk), .rst_n (rst_n), .stim_i (stim_i), .stim_o (stim_o),
      .busy (busy), .mem_en (mem_en), .mem_we (mem_we), .mem_addr (mem_addr),
      .mem_wdata (mem_wdata), .mem_rdata (mem_rdata), .port_sel (port_sel),
      .pout_valid (pout_valid), .pout_ready (pout_ready), .pout_data (pout_data),
      .pin_valid (pin_valid), .pin_ready (pin_ready), .pin_data (pin_data)
   );

   logic [15:0] mem [0:4095];
   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr[11:0]];
      end
   end

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [17:0] sink [0:63];
   logic [17:0] src  [0:63];
   int sink_n = 0, src_n = 0, src_idx = 0, bp_mode = 0, cyc = 0;
   bit src_hs = 0;
   int pulses [0:NM-1];
   int idle_acc = 0, bad_addr = 0;

   always @(negedge clk) begin
      pout_ready = (bp_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      if (pout_valid && pout_ready) begin
         if (sink_n < 64) sink[sink_n] = pout_data;
         sink_n++;
      end
      if (src_hs) src_idx++;
      pin_valid = (src_idx < src_n) && ((bp_mode == 0) || ((cyc % 4) != 1));
      pin_data  = src[src_idx[5:0]];
      src_hs    = pin_valid && pin_ready;
      for (int m = 0; m < NM; m++) if (stim_o[m]) pulses[m]++;
      if (mem_en && !busy) idle_acc++;
      if (mem_en && mem_addr[19:12] != 8'h00 && mem_addr[19:12] != 8'h30) bad_addr++;
      cyc++;
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run_case(input int op, input int cnt, input int bp, input int master);
      logic [15:0] cell0, cellb, hdr;
      int p, k, words;
      bit dir_in, wide;
      dir_in = op[0];
      wide   = op[1];
      cell0  = 16'h8000 | (16'(dir_in) << 14) | (16'(wide) << 13) | 16'(12'h0A0 + op*16 + cnt);
      cellb  = 16'h8155;
      hdr    = 16'(16'h1200 + op*16 + cnt + bp);
      p      = 12'h040 + bp*12'h020;
      mem[BOOT] = 16'(p);
      mem[p]    = hdr;
      mem[p+1] = cell0; mem[p+2] = 16'hFFFC; mem[p+3] = 16'(cnt);
      mem[p+4] = 16'hFFF3; mem[p+5] = 16'h0800;
      mem[p+6] = cellb; mem[p+7] = 16'h0000; mem[p+8] = 16'h0001;
      mem[p+9] = 16'h0003; mem[p+10] = 16'h0900;
      mem[p+11] = 16'(master);
      for (int j = 0; j < 16; j++)
         mem[12'h800 + j] = dir_in ? 16'hDEAD : 16'(16'h9A31 + j*16'h0F13 + op*16'h0101 + cnt);
      mem[12'h900] = 16'h5A5A ^ 16'(op);
      for (int i = 0; i < 8; i++)
         src[i] = 18'(32'h2A5F3 * (i + 1) + op*977 + cnt*131);
      sink_n = 0; src_idx = 0; src_hs = 0; bp_mode = bp;
      src_n  = dir_in ? cnt : 0;
      for (int m = 0; m < NM; m++) pulses[m] = 0;
      @(negedge clk); stim_i = 1'b1;
      @(negedge clk); stim_i = 1'b0;
      if (bp != 0) begin
         repeat (6) @(negedge clk);
         stim_i = 1'b1;                  // R11: restart request while running
         @(negedge clk); stim_i = 1'b0;
      end
      k = 0;
      while (busy && k < 3000) begin @(negedge clk); k++; end
      chk("R10", "run completes", 32'(k < 3000), 32'd1);
      repeat (3) @(negedge clk);
      chk("R2", "port select", 32'(port_sel), 32'(hdr));
      words = 1 + (dir_in ? 0 : cnt) + 2;
      chk("R9", "port word count", 32'(sink_n), 32'(words));
      chk("R4", "routine word first", 32'(sink[0]), 32'(cell0));
      if (!dir_in) begin
         for (int i = 0; i < cnt; i++) begin
            if (wide)
               chk("R6", "wide out word", 32'(sink[1+i]),
                   32'({mem[12'h800 + 2*i][1:0], mem[12'h800 + 2*i + 1]}));
            else
               chk("R5", "narrow out word", 32'(sink[1+i]), 32'(mem[12'h800 + i]));
         end
      end else begin
         for (int i = 0; i < cnt; i++) begin
            if (wide) begin
               chk("R8", "wide in high cell", 32'(mem[12'h800 + 2*i]), 32'(src[i][17:16]));
               chk("R8", "wide in low cell", 32'(mem[12'h800 + 2*i + 1]), 32'(src[i][15:0]));
            end else
               chk("R7", "narrow in cell", 32'(mem[12'h800 + i]), 32'(src[i][15:0]));
         end
         chk("R9", "cell after span untouched",
             32'(mem[12'h800 + (wide ? 2*cnt : cnt)]), 32'h0000DEAD);
      end
      k = 1 + (dir_in ? 0 : cnt);
      chk("R3", "second routine word", 32'(sink[k]), 32'(cellb));
      chk("R3", "second data word", 32'(sink[k+1]), 32'(16'h5A5A ^ 16'(op)));
      for (int m = 0; m < NM; m++)
         chk("R10", "stim pulses", 32'(pulses[m]), (m == master) ? 32'd1 : 32'd0);
      chk("R11", "idle after run", 32'(busy), 32'd0);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
      for (int m = 0; m < NM; m++) pulses[m] = 0;
      repeat (4) @(negedge clk);
      chk("R1", "reset busy", 32'(busy), 32'd0);
      chk("R1", "reset stim_o", 32'(stim_o), 32'd0);
      chk("R1", "reset port/mem", 32'({mem_en, pout_valid, pin_ready}), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      for (int op = 0; op < 4; op++)
         for (int cnt = 0; cnt < 5; cnt++)
            for (int bp = 0; bp < 2; bp++)
               run_case(op, cnt, bp, (op + cnt + bp) % NM);
      chk("R1", "no SRAM access while idle", 32'(idle_acc), 32'd0);
      chk("R3", "addresses from high cells", 32'(bad_addr), 32'd0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 190000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule